// File: doc/BRIEF.md
# SPI command frame receiver

This block is the serial front end of an SPI-to-I2C bridge. It acts as an SPI slave. It oversamples SCLK, MOSI and the active-low select with a faster system clock. It works in all four clock-polarity and clock-phase modes, and the bit order within a byte can be chosen. The serial stream is packed into bytes. Each byte is then checked against a small command grammar.

The grammar has three opcodes. A write frame (0x01) carries an opcode, a count, an address byte and payload. A read frame (0x02) carries an opcode, a count and an address byte. Each accepted byte of these frames is pushed to a transmit queue, together with a two-bit tag that gives its role in the frame. A buffer-read frame (0x03) carries no MOSI data of interest. Instead, the block takes bytes from a first-word-fall-through receive queue and shifts them out on MISO. Malformed frames and queue underflow set sticky flags, which only reset clears.

Top module: `spi_frame_rx`

## Requirements
- R1: For a frame whose opcode is 0x01 or 0x02, the opcode, count and address bytes are each pushed once (one-cycle `tx_push_o`), with tags 0, 1 and 2 respectively and with the data exactly as received.
- R2: A 0x01 frame pushes exactly N payload bytes with tag 3, where N is the count byte, or 256 when the count byte is 0x00. Bytes after the N-th payload byte are not pushed.
- R3: Any byte after the address byte of a 0x02 frame is not pushed. Bit 0 of the address byte must be 0 for opcode 0x01 and 1 for opcode 0x02. On a mismatch the address byte is not pushed, the rest of the frame is discarded and `err_o` is set.
- R4: Any opcode other than 0x01, 0x02 or 0x03 causes no push for the whole frame and sets `err_o`. `err_o` stays set until reset.
- R5: A 0x03 frame pushes nothing, whatever MOSI carries. Every byte after the opcode is driven on MISO from the head of the receive queue. One entry is popped (one-cycle `rx_pop_o`) when the master samples the first bit of that byte, and never when no byte was presented.
- R6: If the receive queue is empty when a buffer-read byte is loaded, that byte is sent as 0xFF, nothing is popped, and `underflow_o` is set once the master samples its first bit. `underflow_o` stays set until reset.
- R7: MOSI is sampled on the leading SCLK edge when CPHA=0 and on the trailing edge when CPHA=1. The leading edge is rising when CPOL=0 and falling when CPOL=1. MISO changes on the other edge, and when CPHA=0 the first bit is valid before the first edge.
- R8: With `lsb_first_i`=0 bytes travel MSB first on both MOSI and MISO. With `lsb_first_i`=1 they travel LSB first.
- R9: Raising the select ends the frame. A partial byte is dropped, and the next frame starts again at the opcode byte. No push or pop happens while the select is high.
- R10: After reset, and whenever the select is idle, `miso_o` is 1. Bytes that are not buffer-read data are sent as 0xFF, and both flags start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Clock polarity (idle level of SCLK) |
| cpha_i | input | 1 | Clock phase (0: sample on leading edge) |
| lsb_first_i | input | 1 | 1: LSB first, 0: MSB first |
| sclk_i | input | 1 | SPI clock from the master |
| cs_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_push_o | output | 1 | One-cycle push strobe to the transmit queue |
| tx_data_o | output | 8 | Byte being pushed |
| tx_tag_o | output | 2 | Role of the byte: 0 opcode, 1 count, 2 address, 3 payload |
| rx_pop_o | output | 1 | One-cycle pop strobe to the receive queue |
| rx_data_i | input | 8 | Head of the receive queue |
| rx_empty_i | input | 1 | Receive queue is empty |
| err_o | output | 1 | Sticky malformed-frame flag |
| underflow_o | output | 1 | Sticky receive-underflow flag |

## Verification
A wrong frame position shows up at the transmit port on the very next completed byte. The byte is pushed with the wrong tag, pushed when it should be dropped, or missing, so the push-by-push comparison catches it within one byte time. A wrong edge choice or bit order corrupts the first byte of a frame. A MISO load or pop that is off by one shows as a misplaced byte on MISO, or as a difference in receive-queue occupancy, by the end of that buffer-read frame. Flag faults are visible at the next frame boundary.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TAG_CMD  = 2'd0,
    TAG_CNT  = 2'd1,
    TAG_ADDR = 2'd2,
    TAG_PAY  = 2'd3
  } frame_tag_e;

  typedef enum logic [2:0] {
    ST_CMD, ST_CNT, ST_ADDR, ST_PAY, ST_BUF, ST_DROP
  } frame_st_e;

  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h01;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_BUFRD = 8'h03;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic cs_act_o,
  output logic sample_o,
  output logic shift_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic sclk_q;
  logic sclk_s, rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_ni};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
      sclk_q <= sclk_p[STAGES-1];
    end
  end

  always_comb begin
    sclk_s   = sclk_p[STAGES-1];
    rise     = sclk_s & ~sclk_q;
    fall     = ~sclk_s & sclk_q;
    lead     = cpol_i ? fall : rise;
    trail    = cpol_i ? rise : fall;
    cs_act_o = ~cs_p[STAGES-1];
    sample_o = cs_act_o & (cpha_i ? trail : lead);
    shift_o  = cs_act_o & (cpha_i ? lead : trail);
    mosi_o   = mosi_p[STAGES-1];
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sample_i,
  input  logic              mosi_i,
  input  logic              lsb_first_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              at_bound_o,
  output logic              first_bit_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] sh, nxt;

  always_comb begin
    nxt = lsb_first_i ? {mosi_i, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], mosi_i};
    at_bound_o  = (bit_cnt == '0);
    first_bit_o = sample_i & at_bound_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt     <= '0;
      sh          <= '0;
      byte_o      <= '0;
      byte_done_o <= 1'b0;
    end else if (!cs_act_i) begin
      bit_cnt     <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (sample_i) begin
        sh      <= nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          bit_cnt     <= '0;
          byte_o      <= nxt;
          byte_done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_frame_pkg::*;
#(
  parameter int MAX_COUNT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] data_o,
  output frame_tag_e        tag_o,
  output logic              buf_mode_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  frame_st_e        state;
  logic [CNT_W-1:0] remain;
  logic             is_read;

  assign buf_mode_o = (state == ST_BUF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_CMD;
      remain  <= '0;
      is_read <= 1'b0;
      push_o  <= 1'b0;
      data_o  <= '0;
      tag_o   <= TAG_CMD;
      err_o   <= 1'b0;
    end else if (!cs_act_i) begin
      state  <= ST_CMD;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (byte_done_i) begin
        data_o <= byte_i;
        unique case (state)
          ST_CMD: begin
            if (byte_i == OP_WRITE || byte_i == OP_READ) begin
              push_o  <= 1'b1;
              tag_o   <= TAG_CMD;
              is_read <= (byte_i == OP_READ);
              state   <= ST_CNT;
            end else if (byte_i == OP_BUFRD) begin
              state <= ST_BUF;
            end else begin
              err_o <= 1'b1;
              state <= ST_DROP;
            end
          end
          ST_CNT: begin
            push_o <= 1'b1;
            tag_o  <= TAG_CNT;
            remain <= (byte_i == '0) ? CNT_W'(MAX_COUNT) : CNT_W'(byte_i);
            state  <= ST_ADDR;
          end
          ST_ADDR: begin
            if (byte_i[0] == is_read) begin
              push_o <= 1'b1;
              tag_o  <= TAG_ADDR;
              state  <= is_read ? ST_DROP : ST_PAY;
            end else begin
              err_o <= 1'b1;
              state <= ST_DROP;
            end
          end
          ST_PAY: begin
            push_o <= 1'b1;
            tag_o  <= TAG_PAY;
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) state <= ST_DROP;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_miso_drv.sv
module spi_miso_drv
  import spi_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              shift_i,
  input  logic              at_bound_i,
  input  logic              first_bit_i,
  input  logic              buf_mode_i,
  input  logic              lsb_first_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_empty_i,
  output logic              miso_o,
  output logic              pop_o,
  output logic              udf_o
);
  logic [BYTE_W-1:0] sh;
  logic              loaded;   // presented byte came from the queue
  logic              starved;  // presented byte is underflow filler

  assign miso_o = lsb_first_i ? sh[0] : sh[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh      <= IDLE_BYTE;
      loaded  <= 1'b0;
      starved <= 1'b0;
      pop_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else if (!cs_act_i) begin
      sh      <= IDLE_BYTE;
      loaded  <= 1'b0;
      starved <= 1'b0;
      pop_o   <= 1'b0;
    end else begin
      pop_o <= 1'b0;
      if (shift_i) begin
        if (at_bound_i) begin
          if (buf_mode_i && !rx_empty_i) begin
            sh      <= rx_data_i;
            loaded  <= 1'b1;
            starved <= 1'b0;
          end else begin
            sh      <= IDLE_BYTE;
            loaded  <= 1'b0;
            starved <= buf_mode_i;
          end
        end else begin
          sh <= lsb_first_i ? {1'b1, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], 1'b1};
        end
      end
      // commit only once the master actually samples the byte
      if (first_bit_i && buf_mode_i) begin
        if (loaded) begin
          pop_o  <= 1'b1;
          loaded <= 1'b0;
        end else if (starved) begin
          udf_o   <= 1'b1;
          starved <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_COUNT   = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpol_i,
  input  logic       cpha_i,
  input  logic       lsb_first_i,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       tx_push_o,
  output logic [7:0] tx_data_o,
  output logic [1:0] tx_tag_o,
  output logic       rx_pop_o,
  input  logic [7:0] rx_data_i,
  input  logic       rx_empty_i,
  output logic       err_o,
  output logic       underflow_o
);
  logic              cs_act, sample, shift, mosi_s;
  logic              byte_done, at_bound, first_bit, buf_mode;
  logic [BYTE_W-1:0] rx_byte;
  frame_tag_e        tag;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cpol_i, .cpha_i, .sclk_i, .cs_ni, .mosi_i,
    .cs_act_o(cs_act), .sample_o(sample), .shift_o(shift), .mosi_o(mosi_s)
  );

  spi_rx_shift u_shift (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .sample_i(sample), .mosi_i(mosi_s),
    .lsb_first_i, .byte_done_o(byte_done), .byte_o(rx_byte),
    .at_bound_o(at_bound), .first_bit_o(first_bit)
  );

  spi_frame_ctl #(.MAX_COUNT(MAX_COUNT)) u_ctl (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .byte_done_i(byte_done), .byte_i(rx_byte),
    .push_o(tx_push_o), .data_o(tx_data_o), .tag_o(tag),
    .buf_mode_o(buf_mode), .err_o(err_o)
  );

  spi_miso_drv u_miso (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .shift_i(shift), .at_bound_i(at_bound),
    .first_bit_i(first_bit), .buf_mode_i(buf_mode), .lsb_first_i,
    .rx_data_i, .rx_empty_i, .miso_o, .pop_o(rx_pop_o), .udf_o(underflow_o)
  );

  assign tx_tag_o = tag;
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_o,
  input logic tx_push_o,
  input logic rx_pop_o,
  input logic rx_empty_i,
  input logic err_o,
  input logic underflow_o
);
  assert_push_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |=> !tx_push_o);

  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_pop_no_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !tx_push_o);

  assert_no_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !$past(rx_empty_i));

  assert_udf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  assert_quiet_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4))
    |-> (!tx_push_o && !rx_pop_o));

  assert_miso_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4))
    |-> miso_o);
endmodule

bind spi_frame_rx spi_frame_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .miso_o(miso_o),
  .tx_push_o(tx_push_o), .rx_pop_o(rx_pop_o), .rx_empty_i(rx_empty_i),
  .err_o(err_o), .underflow_o(underflow_o)
);

// File: tb/tb_spi_frame_rx.sv
module tb_spi_frame_rx;
  localparam int H = 8;  // system clocks per SCLK half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, tx_push, rx_pop, err, udf;
  logic [7:0] tx_data;
  logic [1:0] tx_tag;
  logic [7:0] rx_data = 8'h00;
  logic rx_empty = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [9:0] exp_q[$];
  logic [7:0] rx_q[$], mrx_q[$], got_miso[$], exp_miso[$];
  logic exp_err = 1'b0, exp_udf = 1'b0;

  always #2 clk = ~clk;

  spi_frame_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
    .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .tx_push_o(tx_push), .tx_data_o(tx_data), .tx_tag_o(tx_tag),
    .rx_pop_o(rx_pop), .rx_data_i(rx_data), .rx_empty_i(rx_empty),
    .err_o(err), .underflow_o(udf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of queue traffic against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_push) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, "unexpected push", int'({tx_tag, tx_data}), 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({tx_tag, tx_data} == e, cur_req, "push tag/data", int'({tx_tag, tx_data}), int'(e));
        end
      end
      if (rx_pop) begin
        if (rx_q.size() == 0) check(1'b0, "R6", "pop of empty queue", 1, 0);
        else void'(rx_q.pop_front());
      end
    end
    rx_empty = (rx_q.size() == 0);
    rx_data  = (rx_q.size() != 0) ? rx_q[0] : 8'h00;
  end

  task automatic wait_h(input int n);
    repeat (n * H) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = cpol;
    exp_q.delete(); exp_err = 1'b0; exp_udf = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l);
    cpol = p; cpha = h; lsb = l; sclk = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic preload(input logic [7:0] b);
    rx_q.push_back(b);
    mrx_q.push_back(b);
    repeat (2) @(negedge clk);
  endtask

  // behavioural expectation of one frame
  task automatic model_frame(input logic [7:0] fr[$]);
    int n;
    logic [7:0] op;
    n = 0;
    exp_miso.delete();
    op = fr[0];
    exp_miso.push_back(8'hFF);
    if (op == 8'h01 || op == 8'h02) begin
      exp_q.push_back({2'd0, op});
      for (int k = 1; k < fr.size(); k++) exp_miso.push_back(8'hFF);
      if (fr.size() > 1) begin
        exp_q.push_back({2'd1, fr[1]});
        n = (fr[1] == 8'h00) ? 256 : int'(fr[1]);
      end
      if (fr.size() > 2) begin
        if (fr[2][0] == (op == 8'h02)) begin
          exp_q.push_back({2'd2, fr[2]});
          if (op == 8'h01)
            for (int k = 3; k < fr.size() && (k - 3) < n; k++) exp_q.push_back({2'd3, fr[k]});
        end else exp_err = 1'b1;
      end
    end else if (op == 8'h03) begin
      for (int k = 1; k < fr.size(); k++) begin
        if (mrx_q.size() > 0) exp_miso.push_back(mrx_q.pop_front());
        else begin
          exp_miso.push_back(8'hFF);
          exp_udf = 1'b1;
        end
      end
    end else begin
      exp_err = 1'b1;
      for (int k = 1; k < fr.size(); k++) exp_miso.push_back(8'hFF);
    end
  endtask

  // SPI master: full bytes of fr, then 'extra' bits of a partial byte
  task automatic spi_xfer(input logic [7:0] fr[$], input int extra);
    int nb;
    nb = fr.size();
    got_miso.delete();
    sclk = cpol; cs_n = 1'b0;
    wait_h(2);
    for (int b = 0; b < nb + ((extra > 0) ? 1 : 0); b++) begin
      logic [7:0] rb;
      int nbits;
      rb = 8'h00;
      nbits = (b < nb) ? 8 : extra;
      for (int i = 0; i < nbits; i++) begin
        logic mb, s;
        mb = (b < nb) ? (lsb ? fr[b][i] : fr[b][7-i]) : 1'b1;
        if (!cpha) begin
          mosi = mb; wait_h(1);
          sclk = ~cpol; s = miso; wait_h(1);
          sclk = cpol;
        end else begin
          sclk = ~cpol; mosi = mb; wait_h(1);
          sclk = cpol; s = miso; wait_h(1);
        end
        if (lsb) rb[i] = s; else rb[7-i] = s;
      end
      if (b < nb) got_miso.push_back(rb);
    end
    wait_h(1);
    cs_n = 1'b1;
    wait_h(4);
  endtask

  task automatic run_frame(input logic [7:0] fr[$], input int extra, input string req);
    cur_req = req;
    model_frame(fr);
    spi_xfer(fr, extra);
    check(exp_q.size() == 0, req, "missing pushes", exp_q.size(), 0);
    for (int k = 0; k < got_miso.size(); k++)
      check(got_miso[k] == exp_miso[k], req, $sformatf("MISO byte %0d", k),
            int'(got_miso[k]), int'(exp_miso[k]));
    check(err == exp_err, "R3/R4", "err flag", int'(err), int'(exp_err));
    check(udf == exp_udf, "R6", "underflow flag", int'(udf), int'(exp_udf));
    check(rx_q.size() == mrx_q.size(), "R5", "receive queue level", rx_q.size(), mrx_q.size());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] fr[$];
    do_reset();
    // R10 reset and idle state
    check(tx_push == 1'b0, "R10", "push after reset", int'(tx_push), 0);
    check(rx_pop == 1'b0, "R10", "pop after reset", int'(rx_pop), 0);
    check(err == 1'b0, "R10", "err after reset", int'(err), 0);
    check(udf == 1'b0, "R10", "underflow after reset", int'(udf), 0);
    check(miso == 1'b1, "R10", "idle MISO", int'(miso), 1);

    // R1 R2 R7: mode 0, MSB first, write with one extra byte beyond the count
    set_mode(0, 0, 0);
    fr = '{8'h01, 8'h03, 8'hA0, 8'h11, 8'h22, 8'h33, 8'h44};
    run_frame(fr, 0, "R1/R2");

    // R3 R7 R8: mode 1, LSB first, read frame with a trailing byte ignored
    set_mode(0, 1, 1);
    fr = '{8'h02, 8'h05, 8'hA1, 8'h55};
    run_frame(fr, 0, "R3/R8");

    // R2: count 0x00 means 256, mode 2
    set_mode(1, 0, 0);
    fr = '{8'h01, 8'h00, 8'hA2};
    for (int k = 0; k < 258; k++) fr.push_back(8'(k * 7 + 3));
    run_frame(fr, 0, "R2/R7");

    // R5: buffer read, mode 3 LSB first, MOSI carries opcodes that must be ignored
    set_mode(1, 1, 1);
    preload(8'hC3); preload(8'h5A); preload(8'h81);
    fr = '{8'h03, 8'h01, 8'h02, 8'h01};
    run_frame(fr, 0, "R5/R8");

    // R5: mode 0 buffer read, the look-ahead at the last edge must not pop
    set_mode(0, 0, 0);
    preload(8'h96); preload(8'h3C);
    fr = '{8'h03, 8'hAA};
    run_frame(fr, 0, "R5");

    // R6: queue runs dry during the second data byte
    fr = '{8'h03, 8'h55, 8'h66};
    run_frame(fr, 0, "R6");

    // R9: select rises after three bits of the second byte
    set_mode(0, 1, 0);
    fr = '{8'h01};
    run_frame(fr, 3, "R9");
    fr = '{8'h01, 8'h01, 8'hB0, 8'h99};
    run_frame(fr, 0, "R9");

    // R3: address R/W bit disagrees with the opcode
    fr = '{8'h01, 8'h02, 8'hA3, 8'h77};
    run_frame(fr, 0, "R3");

    // R4: unknown opcode after a fresh reset, then a valid frame; err stays set
    do_reset();
    set_mode(1, 1, 0);
    fr = '{8'h07, 8'h01, 8'hA0};
    run_frame(fr, 0, "R4");
    fr = '{8'h02, 8'h01, 8'hC1};
    run_frame(fr, 0, "R4");
    check(miso == 1'b1, "R10", "idle MISO at end", int'(miso), 1);

    finish_run();
  end
endmodule